// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character at a time into a serial bit stream on a single output line. A character is handed over with a valid/ready handshake. The block then drives it out bit by bit. Each bit stays on the line for a programmable number of clock cycles.

A five-bit mode register sets the shape of the frame. The settings override one another in a fixed order. Synchronous mode wins over everything: only data bits are sent, and a serial clock goes with them. Next, multiprocessor format replaces the parity bit with one extra flag bit. Parity applies only when neither of those is selected.

The mode and the bit period are captured when a character is accepted. Writing the register while a frame is on the line therefore never changes that frame.

Top module: `sertx_frame`

## Requirements
- R1: After reset the mode register is all zeros: no parity, even parity, one stop bit, multiprocessor format off, asynchronous mode. In the same state tx_ready is 1, txd is 1 and sclk is 1.
- R2: A cycle with mode_we high loads mode_in into the mode register. The bit positions are: bit 0 enables parity, bit 1 selects odd parity (0 selects even), bit 2 selects two stop bits, bit 3 selects multiprocessor format, and bit 4 selects clocked synchronous mode.
- R3: An asynchronous frame starts with one 0 bit. Then come DATA_W data bits, LSB first. Every bit lasts exactly bit_cycles clock cycles, and the line is 1 while idle.
- R4: With parity enabled and even parity selected, one parity bit follows the data bits. Its value makes the number of 1s across the data bits and the parity bit even.
- R5: With parity enabled and odd parity selected, the parity bit makes that count of 1s odd.
- R6: The frame ends with one stop bit of value 1. When bit 2 is set, it ends with two stop bits of value 1 instead.
- R7: In multiprocessor format no parity bit is sent, whatever bits 0 and 1 hold. Instead, the value of mp_bit captured at acceptance is sent between the data bits and the stop bits.
- R8: In synchronous mode only the DATA_W data bits are sent, with no start, parity, multiprocessor or stop bit. sclk is 0 for the first bit_cycles/2 (rounded down) cycles of each data bit and 1 for the remaining cycles. sclk stays 1 outside a frame.
- R9: The mode register and bit_cycles are captured when a character is accepted. A change made during a frame affects only the next frame.
- R10: A character is accepted on a clock edge where tx_valid and tx_ready are both 1. After that edge tx_ready is 0 until the last bit of the frame has lasted its full period. tx_ready returns to 1 in the cycle that follows. While tx_valid is 0 the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Mode register write strobe |
| mode_in | input | 5 | Mode register write value |
| bit_cycles | input | CNT_W | Clock cycles per serial bit |
| tx_data | input | DATA_W | Character to send |
| tx_valid | input | 1 | Character offered |
| mp_bit | input | 1 | Multiprocessor flag value for the character |
| tx_ready | output | 1 | Block idle and able to accept a character |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock, synchronous mode only |

## Verification
The assertions take for granted that bit_cycles is at least 2 whenever a character is accepted. With that bound, every bit has a low phase and a high phase of the serial clock, and the line-hold check in synchronous mode has a meaning.

The assertions also take for granted that inputs change only between clock edges. The stimulus meets both conditions: it uses bit periods of 2 to 5 cycles, and it drives every input on the falling clock edge. Mode writes are timed to land inside a running frame as well as between frames.

// File: rtl/sertx_frame.sv
module sertx_frame #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [4:0]        mode_in,
  input  logic [CNT_W-1:0]  bit_cycles,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              mp_bit,
  output logic              tx_ready,
  output logic              txd,
  output logic              sclk
);
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_MPB, S_STOP1, S_STOP2
  } st_t;

  st_t               st;
  logic [4:0]        mode_q;
  logic [CNT_W-1:0]  cnt, bc_q;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              par_q, mpb_q;
  logic              f_par, f_mp, f_two, f_sync;

  wire accept   = tx_valid && tx_ready;
  wire e_sync   = mode_q[4];
  wire e_mp     = mode_q[3] && !e_sync;
  wire e_par    = mode_q[0] && !e_mp && !e_sync;
  wire e_two    = mode_q[2] && !e_sync;
  wire bit_last = (cnt == bc_q - CNT_W'(1));

  assign tx_ready = (st == S_IDLE);
  assign sclk = !(st == S_DATA && f_sync && cnt < (bc_q >> 1));

  always_comb begin
    case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = shreg[0];
      S_PAR:   txd = par_q;
      S_MPB:   txd = mpb_q;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_we) mode_q <= mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bc_q <= CNT_W'(1);
      shreg <= '0;
      idx <= '0;
      par_q <= 1'b0;
      mpb_q <= 1'b0;
      f_par <= 1'b0;
      f_mp <= 1'b0;
      f_two <= 1'b0;
      f_sync <= 1'b0;
    end else if (st == S_IDLE) begin
      if (accept) begin
        st <= e_sync ? S_DATA : S_START;
        cnt <= '0;
        bc_q <= (bit_cycles == '0) ? CNT_W'(1) : bit_cycles;
        shreg <= tx_data;
        idx <= '0;
        par_q <= (^tx_data) ^ mode_q[1];
        mpb_q <= mp_bit;
        f_par <= e_par;
        f_mp <= e_mp;
        f_two <= e_two;
        f_sync <= e_sync;
      end
    end else if (!bit_last) begin
      cnt <= cnt + CNT_W'(1);
    end else begin
      cnt <= '0;
      case (st)
        S_START: st <= S_DATA;
        S_DATA: begin
          shreg <= shreg >> 1;
          idx <= idx + IDX_W'(1);
          if (idx == LAST_IDX)
            st <= f_sync ? S_IDLE : f_par ? S_PAR : f_mp ? S_MPB : S_STOP1;
        end
        S_PAR, S_MPB: st <= S_STOP1;
        S_STOP1: st <= f_two ? S_STOP2 : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sertx_frame_chk.sv
module sertx_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic sclk,
  input logic f_sync
);
  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_ready);

  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (txd && sclk));

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_ready) && !f_sync) |-> !txd);

  // R8
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_sync && !tx_ready && $past(!tx_ready) && !$fell(sclk)) |-> $stable(txd));
endmodule

bind sertx_frame sertx_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .txd(txd), .sclk(sclk), .f_sync(f_sync)
);

// File: tb/sertx_frame_tb.sv
module sertx_frame_tb;
  logic clk = 0, rst_n = 0, mode_we = 0, tx_valid = 0, mp_bit = 0;
  logic [4:0] mode_in = '0;
  logic [15:0] bit_cycles = 16'd4;
  logic [7:0] tx_data = '0;
  logic tx_ready, txd, sclk;
  int checks = 0, failures = 0;
  logic [4:0] mode_sh = '0;

  always #5 clk = ~clk;

  sertx_frame u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [4:0] m);
    @(negedge clk); mode_we = 1; mode_in = m;
    @(negedge clk); mode_we = 0;
    mode_sh = m;
  endtask

  task automatic run_frame(input logic [7:0] d, input logic mp, input int bc,
                           input string req, input bit chg, input logic [4:0] chg_mode);
    logic [11:0] bits;
    int n, nb;
    logic [4:0] m;
    bit sy, mpf, pe;
    m = mode_sh;
    sy = m[4]; mpf = m[3] && !sy; pe = m[0] && !mpf && !sy;
    nb = 0;
    if (!sy) begin bits[nb] = 0; nb++; end
    for (int i = 0; i < 8; i++) begin bits[nb] = d[i]; nb++; end
    if (pe) begin bits[nb] = (^d) ^ m[1]; nb++; end
    if (mpf) begin bits[nb] = mp; nb++; end
    if (!sy) begin
      bits[nb] = 1; nb++;
      if (m[2]) begin bits[nb] = 1; nb++; end
    end
    @(negedge clk);
    chk(tx_ready, req, tx_ready, 1);
    tx_data = d; mp_bit = mp; bit_cycles = 16'(bc); tx_valid = 1;
    @(negedge clk);
    tx_valid = 0; bit_cycles = 16'd3; mp_bit = ~mp;
    for (n = 0; n < nb * bc; n++) begin
      if (chg && n == 5) begin mode_we = 1; mode_in = chg_mode; end
      if (chg && n == 6) begin mode_we = 0; mode_sh = chg_mode; end
      if (n % bc == bc / 2) chk(txd == bits[n / bc], req, txd, bits[n / bc]);
      if (sy && n % bc == 0) chk(sclk == 0, req, sclk, 0);
      if (sy && n % bc == bc / 2) chk(sclk == 1, req, sclk, 1);
      if (n == nb * bc - 1) chk(!tx_ready, "R10", tx_ready, 0);
      @(negedge clk);
    end
    chk(tx_ready && txd && sclk, "R10", {tx_ready, txd, sclk}, 7);
  endtask

  task automatic t_reset();
    chk(tx_ready && txd && sclk, "R1", {tx_ready, txd, sclk}, 7);
    run_frame(8'hA5, 1'b1, 4, "R1", 0, '0);
  endtask

  task automatic t_basic();
    run_frame(8'h3C, 1'b0, 2, "R3", 0, '0);
    run_frame(8'h81, 1'b0, 5, "R3", 0, '0);
  endtask

  task automatic t_even();
    write_mode(5'b00001);
    run_frame(8'h07, 1'b0, 4, "R4", 0, '0);
    run_frame(8'h03, 1'b0, 4, "R4", 0, '0);
  endtask

  task automatic t_odd();
    write_mode(5'b00011);
    run_frame(8'h07, 1'b0, 4, "R5", 0, '0);
    run_frame(8'h00, 1'b0, 3, "R5", 0, '0);
  endtask

  task automatic t_stop();
    write_mode(5'b00100);
    run_frame(8'hF0, 1'b0, 4, "R6", 0, '0);
    write_mode(5'b00111);
    run_frame(8'h01, 1'b0, 2, "R6", 0, '0);
  endtask

  task automatic t_mp();
    write_mode(5'b01011);
    run_frame(8'h55, 1'b1, 4, "R7", 0, '0);
    run_frame(8'h55, 1'b0, 4, "R7", 0, '0);
  endtask

  task automatic t_sync();
    write_mode(5'b11111);
    run_frame(8'hC9, 1'b1, 4, "R8", 0, '0);
    run_frame(8'h36, 1'b0, 2, "R8", 0, '0);
  endtask

  task automatic t_boundary();
    write_mode(5'b00000);
    run_frame(8'h5A, 1'b0, 4, "R9", 1, 5'b00101);
    run_frame(8'h5A, 1'b0, 4, "R9", 0, '0);
    run_frame(8'hE1, 1'b0, 3, "R2", 0, '0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(tx_ready && txd, "R10", {tx_ready, txd}, 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_even();
    t_odd();
    t_stop();
    t_mp();
    t_sync();
    t_boundary();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule